// File: doc/BRIEF.md
# Serial Output-Enable Controller

This block is a receive-only two-wire serial slave that holds one enable bit for each of 18 clock fanout outputs. A bus master writes the bits with block-write transfers. SCL and SDA are sampled in a fast system clock. The block finds start and stop conditions and checks a fixed 7-bit address. It acknowledges each accepted byte by pulling SDA low, and it routes the data bytes into the enable bits purely by their position in the transfer.

The command-code byte and the byte-count byte that follow the address are acknowledged and then discarded. The block also has a global active-low tri-state input. While that input is low, every output enable reads as off, whatever the register contents. The block only ever writes, and its only drive of SDA is the acknowledge pulse. There is no data stream at its edge, so every pin is a plain level with no valid/ready handshake and no back-pressure.

Top module: `oe_serial_ctrl`

## Requirements
- R1: A start condition is SDA falling while SCL is high, and a stop condition is SDA rising while SCL is high. A start seen in the middle of a transfer (a repeated start) returns byte parsing to the address byte.
- R2: Only the first byte 0xD2 is acknowledged, which is address 1101001 followed by a write bit of 0. Any other first byte, including 0xD3 with the read bit set, gets no acknowledge, and the bus is then ignored until the next start.
- R3: For each accepted byte, sda_pull_o goes high only while SCL is low after the eighth bit. It stays high through the ninth SCL high phase and is released after the ninth SCL falling edge. This repeats for every byte until a stop, and a stop always releases it.
- R4: The second and third bytes after a start (command code and byte count) are acknowledged and change no enable bit.
- R5: Bits arrive most significant first. Data byte 0 loads enables 7..0, with bit 7 driving output 7. Data byte 1 loads enables 15..8. A 1 enables an output and a 0 disables it.
- R6: In data byte 2, bit 7 loads enable 17 and bit 6 loads enable 16, and bits 5..0 are ignored. Data bytes 3 and later are acknowledged and change no enable bit.
- R7: A data byte is committed only when it is acknowledged. A byte cut short by a stop has no effect, and enable bits whose bytes were not sent keep their values.
- R8: After reset all 18 enable bits are 1 and sda_pull_o is 0.
- R9: While glb_oe_i is 0, out_en_o is all zero. While it is 1, out_en_o equals the enable bits, and the bits are kept across periods with glb_oe_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the wired bus |
| glb_oe_i | input | 1 | Global output enable; 0 tri-states every output |
| sda_pull_o | output | 1 | 1 pulls SDA low for an acknowledge |
| out_en_o | output | 18 | Gated per-output drive enables |

## Verification
Committing a received byte into the enable bits and gating the outputs through the global enable can fall in the same system clock. The bench provokes this by dropping glb_oe_i just after the eighth SCL falling edge of a data byte and holding it low across the clock in which that byte is committed. It then checks that out_en_o reads zero during the acknowledge. After glb_oe_i rises again, out_en_o must show the newly committed byte rather than the old value. Randomised transfers that mix wrong addresses, truncated bytes and over-long writes are judged against a bench model of the enable bits.

// File: rtl/oe_ctrl_pkg.sv
package oe_ctrl_pkg;

  // Bus events derived from the synchronised serial lines.
  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_evt_t;

endpackage

// File: rtl/oe_bus_sync.sv
module oe_bus_sync
  import oe_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic                   scl_q;
  logic                   sda_q;
  logic                   scl_s;
  logic                   sda_s;

  // The idle bus is high, so every stage resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[SYNC_STAGES-1];
      sda_q    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];

  always_comb begin
    evt_o.scl      = scl_s;
    evt_o.sda      = sda_s;
    evt_o.scl_rise = scl_s & ~scl_q;
    evt_o.scl_fall = ~scl_s & scl_q;
    evt_o.start    = scl_s & scl_q & sda_q & ~sda_s;
    evt_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/oe_byte_rx.sv
module oe_byte_rx
  import oe_ctrl_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int         HDR_BYTES  = 2,
  parameter int         IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_evt_t         evt_i,
  output logic             ack_o,
  output logic             wr_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o
);

  localparam logic [7:0]       ADDR_BYTE  = {SLAVE_ADDR, 1'b0};
  localparam logic [IDX_W-1:0] FIRST_DATA = IDX_W'(HDR_BYTES + 1);

  logic             active;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg;
  logic [IDX_W-1:0] byte_idx;
  logic             decide;
  logic             addr_ok;

  // Falling SCL after the eighth bit: the accept/reject point for a byte.
  assign decide  = active & evt_i.scl_fall & (bit_cnt == 4'd8) & ~ack_o;
  assign addr_ok = (shreg == ADDR_BYTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_idx  <= '0;
      ack_o     <= 1'b0;
      wr_o      <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_o <= 1'b0;
      if (evt_i.start) begin
        active   <= 1'b1;
        bit_cnt  <= '0;
        byte_idx <= '0;
        ack_o    <= 1'b0;
      end else if (evt_i.stop) begin
        active  <= 1'b0;
        bit_cnt <= '0;
        ack_o   <= 1'b0;
      end else if (active) begin
        if (evt_i.scl_rise && bit_cnt < 4'd9) begin
          if (bit_cnt < 4'd8) shreg <= {shreg[6:0], evt_i.sda};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (decide) begin
          if (byte_idx == '0 && !addr_ok) begin
            active <= 1'b0;
          end else begin
            ack_o <= 1'b1;
            if (byte_idx >= FIRST_DATA) begin
              wr_o      <= 1'b1;
              wr_idx_o  <= byte_idx - FIRST_DATA;
              wr_data_o <= shreg;
            end
          end
        end else if (evt_i.scl_fall && bit_cnt == 4'd9) begin
          ack_o   <= 1'b0;
          bit_cnt <= '0;
          if (byte_idx != '1) byte_idx <= byte_idx + 1'b1;
        end
      end
    end
  end

  // R3: the acknowledge is only raised while SCL is low.
  p_ack_rise_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> !evt_i.scl);

  // R3: a stop releases the line.
  p_stop_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.stop |=> !ack_o);

  // R2: a wrong first byte gets no acknowledge and parsing stops.
  p_bad_addr_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && byte_idx == '0 && !addr_ok && !evt_i.start && !evt_i.stop)
      |=> (!ack_o && !active));

  // R7: a commit always comes with an acknowledge.
  p_commit_with_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> ack_o);

  // R1: a start returns parsing to the address byte.
  p_start_rewind_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.start |=> (byte_idx == '0 && bit_cnt == '0 && !ack_o && active));

endmodule

// File: rtl/oe_enable_regs.sv
module oe_enable_regs #(
  parameter int NUM_OUT = 18,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [7:0]         wr_data_i,
  input  logic               glb_oe_i,
  output logic [NUM_OUT-1:0] out_en_o
);

  localparam int FULL_BYTES = NUM_OUT / 8;
  localparam int REM_BITS   = NUM_OUT % 8;
  localparam int NUM_BYTES  = (NUM_OUT + 7) / 8;

  logic [NUM_OUT-1:0] en_q;

  // A partial last byte fills from its top bit down; the low bits are unused.
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
    localparam int BI = (i < FULL_BYTES * 8) ? (i / 8) : FULL_BYTES;
    localparam int BB = (i < FULL_BYTES * 8) ? (i % 8) : (8 - REM_BITS + (i - FULL_BYTES * 8));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                en_q[i] <= 1'b1;
      else if (wr_i && wr_idx_i == IDX_W'(BI))   en_q[i] <= wr_data_i[BB];
    end
  end

  assign out_en_o = glb_oe_i ? en_q : '0;

  // R7: bits change only on a commit.
  p_hold_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(en_q));

  // R6: data bytes past the last register leave every bit alone.
  p_extra_bytes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wr_idx_i >= IDX_W'(NUM_BYTES)) |=> $stable(en_q));

endmodule

// File: rtl/oe_serial_ctrl.sv
module oe_serial_ctrl
  import oe_ctrl_pkg::*;
#(
  parameter int         NUM_OUT     = 18,
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         SYNC_STAGES = 2,
  parameter int         HDR_BYTES   = 2,
  parameter int         IDX_W       = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               glb_oe_i,
  output logic               sda_pull_o,
  output logic [NUM_OUT-1:0] out_en_o
);

  bus_evt_t         evt;
  logic             wr;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  oe_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt_o (evt)
  );

  oe_byte_rx #(
    .SLAVE_ADDR (SLAVE_ADDR),
    .HDR_BYTES  (HDR_BYTES),
    .IDX_W      (IDX_W)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt),
    .ack_o     (sda_pull_o),
    .wr_o      (wr),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data)
  );

  oe_enable_regs #(.NUM_OUT(NUM_OUT), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (wr),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .glb_oe_i  (glb_oe_i),
    .out_en_o  (out_en_o)
  );

  // R9: with the global enable low no output is driven.
  p_global_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_oe_i |-> (out_en_o == '0));

endmodule

// File: tb/oe_serial_ctrl_tb.sv
module oe_serial_ctrl_tb;

  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        glb_oe = 1'b1;
  logic        sda_pull;
  logic [17:0] out_en;
  logic        sda_bus;
  logic [17:0] exp_en;
  int          n_chk = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  oe_serial_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .glb_oe_i   (glb_oe),
    .sda_pull_o (sda_pull),
    .out_en_o   (out_en)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [17:0] apply(input logic [17:0] cur, input int idx, input logic [7:0] b);
    logic [17:0] r = cur;
    case (idx)
      0: r[7:0]   = b;
      1: r[15:8]  = b;
      2: r[17:16] = b[7:6];
      default: ;
    endcase
    return r;
  endfunction

  task automatic bus_start();
    wclk(2); sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    wclk(2); sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(Q); sda_m = 1'b1; wclk(Q);
  endtask

  task automatic send_bit(input logic b);
    wclk(2); sda_m = b; wclk(Q); scl_m = 1'b1; wclk(Q); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req, input logic drop_oe);
    logic got;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    if (drop_oe) glb_oe = 1'b0;
    wclk(2); sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q / 2);
    got = sda_pull;
    chk(got == exp_ack, req, 32'(got), 32'(exp_ack));
    if (drop_oe) chk(out_en == '0, "R9 gate during commit", 32'(out_en), 0);
    wclk(Q / 2); scl_m = 1'b0;
  endtask

  task automatic check_out(input string req);
    wclk(4);
    chk(out_en == (glb_oe ? exp_en : 18'h0), req, 32'(out_en), 32'(glb_oe ? exp_en : 18'h0));
  endtask

  task automatic write_all(input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    bus_start();
    send_byte(8'hD2, 1'b1, "R2 addr ack", 1'b0);
    send_byte(8'h5A, 1'b1, "R4 cmd ack", 1'b0);
    send_byte(8'h03, 1'b1, "R4 count ack", 1'b0);
    send_byte(d0, 1'b1, "R5 data0 ack", 1'b0);
    send_byte(d1, 1'b1, "R5 data1 ack", 1'b0);
    send_byte(d2, 1'b1, "R6 data2 ack", 1'b0);
    bus_stop();
    exp_en = apply(exp_en, 0, d0);
    exp_en = apply(exp_en, 1, d1);
    exp_en = apply(exp_en, 2, d2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    exp_en = '1;
    wclk(5);
    chk(out_en == '1, "R8 reset enables", 32'(out_en), 32'h3FFFF);
    chk(sda_pull == 1'b0, "R8 reset no pull", 32'(sda_pull), 0);
    rst_n = 1'b1;
    wclk(5);
    chk(out_en == '1, "R8 after reset", 32'(out_en), 32'h3FFFF);

    // R9: global gate
    glb_oe = 1'b0; check_out("R9 global off");
    glb_oe = 1'b1; check_out("R9 global on");

    // R5 R6: full write, reserved bits set
    write_all(8'hA5, 8'h3C, 8'h7F);
    check_out("R6 reserved ignored, bit7->17 bit6->16");
    write_all(8'h5A, 8'hC3, 8'h80);
    check_out("R5 byte order and msb first");

    // R6: extra data bytes acked, no effect
    bus_start();
    send_byte(8'hD2, 1'b1, "R2 addr ack", 1'b0);
    send_byte(8'h00, 1'b1, "R4 cmd ack", 1'b0);
    send_byte(8'hFF, 1'b1, "R4 count ack", 1'b0);
    send_byte(8'h0F, 1'b1, "R5 data0 ack", 1'b0);
    exp_en = apply(exp_en, 0, 8'h0F);
    send_byte(8'hF0, 1'b1, "R5 data1 ack", 1'b0);
    exp_en = apply(exp_en, 1, 8'hF0);
    send_byte(8'h40, 1'b1, "R6 data2 ack", 1'b0);
    exp_en = apply(exp_en, 2, 8'h40);
    for (int k = 0; k < 5; k++) send_byte(8'h00, 1'b1, "R6 extra ack", 1'b0);
    bus_stop();
    check_out("R6 extra bytes ignored");

    // R2: read bit and wrong address
    bus_start();
    send_byte(8'hD3, 1'b0, "R2 read bit no ack", 1'b0);
    send_byte(8'h00, 1'b0, "R2 ignored after nack", 1'b0);
    send_byte(8'h00, 1'b0, "R2 ignored after nack", 1'b0);
    send_byte(8'h00, 1'b0, "R2 ignored after nack", 1'b0);
    bus_stop();
    check_out("R2 read bit no effect");
    bus_start();
    send_byte(8'hA2, 1'b0, "R2 wrong addr no ack", 1'b0);
    send_byte(8'h11, 1'b0, "R2 ignored", 1'b0);
    send_byte(8'h11, 1'b0, "R2 ignored", 1'b0);
    send_byte(8'h11, 1'b0, "R2 ignored", 1'b0);
    bus_stop();
    check_out("R2 wrong addr no effect");

    // R1: repeated start re-parses from the address
    bus_start();
    send_byte(8'hD2, 1'b1, "R1 addr ack", 1'b0);
    send_byte(8'h01, 1'b1, "R4 cmd ack", 1'b0);
    send_byte(8'h02, 1'b1, "R4 count ack", 1'b0);
    send_byte(8'h11, 1'b1, "R1 data0 ack", 1'b0);
    exp_en = apply(exp_en, 0, 8'h11);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte(8'hD2, 1'b1, "R1 addr after restart", 1'b0);
    send_byte(8'h01, 1'b1, "R1 cmd after restart", 1'b0);
    send_byte(8'h02, 1'b1, "R1 count after restart", 1'b0);
    send_byte(8'h22, 1'b1, "R1 data0 after restart", 1'b0);
    exp_en = apply(exp_en, 0, 8'h22);
    send_byte(8'h33, 1'b1, "R1 data1 after restart", 1'b0);
    exp_en = apply(exp_en, 1, 8'h33);
    bus_stop();
    check_out("R1 repeated start positions");

    // R7: truncated byte
    bus_start();
    send_byte(8'hD2, 1'b1, "R7 addr ack", 1'b0);
    send_byte(8'h00, 1'b1, "R7 cmd ack", 1'b0);
    send_byte(8'h00, 1'b1, "R7 count ack", 1'b0);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    bus_stop();
    check_out("R7 truncated byte no effect");

    // R9 with commit: global enable low across the commit
    bus_start();
    send_byte(8'hD2, 1'b1, "R3 addr ack", 1'b0);
    send_byte(8'h00, 1'b1, "R3 cmd ack", 1'b0);
    send_byte(8'h00, 1'b1, "R3 count ack", 1'b0);
    send_byte(8'h96, 1'b1, "R3 data0 ack", 1'b1);
    exp_en = apply(exp_en, 0, 8'h96);
    bus_stop();
    check_out("R9 gated after commit");
    glb_oe = 1'b1;
    check_out("R9 committed byte visible");

    // Random transfers
    for (int t = 0; t < 40; t++) begin
      logic [7:0] addr;
      logic       ok;
      int         nb;
      addr = ($urandom % 6 == 0) ? 8'($urandom) : 8'hD2;
      ok   = (addr == 8'hD2);
      nb   = $urandom % 9;
      bus_start();
      send_byte(addr, ok, "R2 random addr", 1'b0);
      for (int k = 0; k < nb; k++) begin
        logic [7:0] d;
        d = 8'($urandom);
        send_byte(d, ok, "R3 random byte ack", 1'b0);
        if (ok && k >= 2) exp_en = apply(exp_en, k - 2, d);
      end
      if ($urandom % 5 == 0) begin
        int nbits;
        nbits = 1 + ($urandom % 7);
        for (int i = 0; i < nbits; i++) send_bit(1'($urandom));
      end
      bus_stop();
      glb_oe = 1'($urandom % 4 != 0);
      check_out("R7 random transfer result");
      glb_oe = 1'b1;
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule